// File: doc/BRIEF.md
# One-Time-Programmable Register Lock Controller

This block is a byte-level command processor. It sits behind a single-wire bus layer that has already turned bit slots into whole bytes. The processor looks after three pieces of storage: an eight-byte staging buffer, an eight-byte one-time-programmable (OTP) register and a status byte that is derived from a lock flag. The bus layer passes each received byte in on a valid/ready stream. It takes each byte to be returned on a second valid/ready stream, where the master's read-request acts as the ready. A plain `bus_reset` pulse ends the current transaction.

Four commands are supported: stage writes, status read, register read and copy-and-lock. The copy moves the whole staging buffer into the OTP register and sets the lock in the same clock edge, and it can happen only once. After that, the status byte reads FCh instead of FFh, register reads return the OTP contents instead of the buffer, and any further writes or copies change nothing. The lock and both storage arrays are cleared only by the power-on reset `rst_n`, which models the unprogrammed part. A bus reset keeps all of them.

Stream rules: a byte moves on `rx` when `rx_valid` and `rx_ready` are both high at a clock edge, and on `tx` when `tx_valid` and `tx_ready` are both high. `rx_ready` is low exactly while a byte is being offered on `tx`. An offered byte is held until it is taken. The source may hold off bytes indefinitely with `rx_valid`, and the sink may hold off with `tx_ready`.

Top module: `otp_lock_ctrl`

## Requirements
- R1: Command 99h, then an address byte whose low 3 bits give the start index (upper bits ignored). Each data byte accepted after that is written to the staging buffer at the current index. The index then advances, wrapping from 7 to 0, until a bus reset.
- R2: `rx_ready` and `tx_valid` are never high together. While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays stable.
- R3: Command C3h, then an address byte whose low 3 bits give the start index. Each byte offered and taken comes from the current index, which then advances and wraps from 7 to 0. While the controller is unlocked, these bytes come from the staging buffer.
- R4: Command 66h followed by key 00h offers the status byte: FFh while unlocked and FCh once locked. Every later read request returns the status byte again until a bus reset.
- R5: Command 66h followed by any key other than 00h offers no byte until a bus reset.
- R6: Command 5Ah followed by key A5h, while unlocked, copies all eight staging bytes into the OTP register and sets the lock on the same edge. From then on, C3h returns OTP contents and status reads FCh.
- R7: Command 5Ah followed by a key other than A5h, or by a bus reset in place of the key, neither copies nor locks.
- R8: Once locked, the data bytes of command 99h are accepted and discarded, and the OTP register never changes.
- R9: A second 5Ah/A5h sequence after locking leaves the OTP contents and the status byte unchanged.
- R10: `bus_reset` returns the controller to waiting for a command on the next edge and stops any offered byte. It takes priority over a byte accepted in the same cycle, so a key presented alongside it has no effect. Lock and storage are kept.
- R11: An unrecognised command byte makes the controller accept and discard all following bytes and offer none until a bus reset.
- R12: After `rst_n`, the controller is unlocked, both arrays hold zero, `rx_ready` is high and `tx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, clears lock and storage |
| bus_reset | input | 1 | Synchronous bus reset pulse, ends the transaction |
| rx_valid | input | 1 | Received byte is present |
| rx_ready | output | 1 | Controller can take a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte to return is present |
| tx_ready | input | 1 | Master read-request for the offered byte |
| tx_data | output | 8 | Byte to return |

## Verification
Two events can land on the same edge: a bus reset, and the acceptance of the copy-and-lock key. The bench provokes this by presenting A5h with `rx_valid` high in the cycle where `bus_reset` is also high. It judges the result at the ports: a following status read must still return FFh, and a register read must still return the staging contents. It also stalls the return stream in mid-read to check that the offered byte holds.

// File: rtl/otp_lock_pkg.sv
package otp_lock_pkg;
  localparam logic [7:0] CMD_STAGE_WR = 8'h99;
  localparam logic [7:0] CMD_STATUS   = 8'h66;
  localparam logic [7:0] CMD_REG_RD   = 8'hC3;
  localparam logic [7:0] CMD_SEAL     = 8'h5A;
  localparam logic [7:0] KEY_SEAL     = 8'hA5;
  localparam logic [7:0] KEY_STATUS   = 8'h00;
  localparam logic [7:0] STAT_OPEN    = 8'hFF;
  localparam logic [7:0] STAT_SEALED  = 8'hFC;

  typedef enum logic [3:0] {
    ST_CMD,
    ST_WADDR,
    ST_WDATA,
    ST_SKEY,
    ST_SOUT,
    ST_RADDR,
    ST_ROUT,
    ST_LKEY,
    ST_SINK
  } fsm_state_t;
endpackage

// File: rtl/otp_cmd_fsm.sv
module otp_cmd_fsm
  import otp_lock_pkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_reset,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  output logic             rx_ready,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic             sel_status,
  output logic [IDX_W-1:0] idx,
  output logic             wr_en,
  output logic             copy_en
);
  fsm_state_t state_q, state_d;
  logic rx_fire, tx_fire, load_idx, step_idx;

  assign tx_valid   = (state_q == ST_SOUT) || (state_q == ST_ROUT);
  assign rx_ready   = !tx_valid;
  assign sel_status = (state_q == ST_SOUT);
  assign rx_fire    = rx_valid && rx_ready;
  assign tx_fire    = tx_valid && tx_ready;

  assign wr_en    = rx_fire && (state_q == ST_WDATA) && !bus_reset;
  assign copy_en  = rx_fire && (state_q == ST_LKEY) && (rx_data == KEY_SEAL) && !bus_reset;
  assign load_idx = rx_fire && ((state_q == ST_WADDR) || (state_q == ST_RADDR));
  assign step_idx = wr_en || (tx_fire && (state_q == ST_ROUT));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CMD: if (rx_fire) begin
        unique case (rx_data)
          CMD_STAGE_WR: state_d = ST_WADDR;
          CMD_STATUS:   state_d = ST_SKEY;
          CMD_REG_RD:   state_d = ST_RADDR;
          CMD_SEAL:     state_d = ST_LKEY;
          default:      state_d = ST_SINK;
        endcase
      end
      ST_WADDR: if (rx_fire) state_d = ST_WDATA;
      ST_SKEY:  if (rx_fire) state_d = (rx_data == KEY_STATUS) ? ST_SOUT : ST_SINK;
      ST_RADDR: if (rx_fire) state_d = ST_ROUT;
      ST_LKEY:  if (rx_fire) state_d = ST_SINK;
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CMD;
      idx     <= '0;
    end else if (bus_reset) begin
      state_q <= ST_CMD;
    end else begin
      state_q <= state_d;
      if (load_idx)      idx <= rx_data[IDX_W-1:0];
      else if (step_idx) idx <= idx + 1'b1;
    end
  end

  assert_bus_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> (rx_ready && !tx_valid));

  assert_sink_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SINK && !bus_reset) |=> !tx_valid);

  assert_bad_key_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKEY && rx_fire && rx_data != KEY_STATUS && !bus_reset) |=> !tx_valid);
endmodule

// File: rtl/otp_reg_store.sv
module otp_reg_store #(
  parameter int NBYTES = 8,
  parameter int IDX_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wr_data,
  input  logic             copy_en,
  output logic [7:0]       rd_data,
  output logic             locked
);
  logic [NBYTES-1:0][7:0] stage_q;
  logic [NBYTES-1:0][7:0] otp_q;
  logic                   locked_q;

  assign locked  = locked_q;
  assign rd_data = locked_q ? otp_q[idx] : stage_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      otp_q    <= '0;
      locked_q <= 1'b0;
    end else begin
      if (wr_en && !locked_q) stage_q[idx] <= wr_data;
      if (copy_en && !locked_q) begin
        otp_q    <= stage_q;
        locked_q <= 1'b1;
      end
    end
  end

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q);

  assert_otp_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(otp_q));

  assert_stage_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(stage_q));

  assert_copy_and_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_en && !locked_q) |=> (locked_q && otp_q == $past(stage_q)));
endmodule

// File: rtl/otp_lock_ctrl.sv
module otp_lock_ctrl
  import otp_lock_pkg::*;
#(
  parameter int NBYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_reset,
  input  logic       rx_valid,
  output logic       rx_ready,
  input  logic [7:0] rx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data
);
  localparam int IDX_W = $clog2(NBYTES);

  logic             sel_status, wr_en, copy_en, locked;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rd_data, status_byte;

  otp_cmd_fsm #(.IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready),
    .sel_status(sel_status), .idx(idx), .wr_en(wr_en), .copy_en(copy_en)
  );

  otp_reg_store #(.NBYTES(NBYTES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx), .wr_data(rx_data),
    .copy_en(copy_en), .rd_data(rd_data), .locked(locked)
  );

  assign status_byte = locked ? STAT_SEALED : STAT_OPEN;
  assign tx_data     = sel_status ? status_byte : rd_data;

  assert_stream_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_ready));

  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !bus_reset) |=> (tx_valid && $stable(tx_data)));
endmodule

// File: tb/otp_lock_ctrl_bench.sv
module otp_lock_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_reset = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = 8'h00;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_stage [8];
  logic [7:0] exp_otp [8];

  always #5 clk = ~clk;

  otp_lock_ctrl u_otp_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_data = b;
    rx_valid = 1'b1;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic recv(output logic [7:0] b);
    @(negedge clk);
    tx_ready = 1'b1;
    while (!tx_valid) @(negedge clk);
    b = tx_data;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic breset();
    @(negedge clk);
    bus_reset = 1'b1;
    @(negedge clk);
    bus_reset = 1'b0;
  endtask

  task automatic read_status(input string tag, input logic [7:0] exp, input int n);
    logic [7:0] b;
    send(8'h66);
    send(8'h00);
    for (int k = 0; k < n; k++) begin
      recv(b);
      check(tag, b, exp);
    end
    breset();
  endtask

  task automatic read_all(input string tag, input logic locked_exp);
    logic [7:0] b;
    for (int s = 0; s < 8; s++) begin
      send(8'hC3);
      send(8'(s));
      for (int k = 0; k < 9; k++) begin
        recv(b);
        check(tag, b, locked_exp ? exp_otp[(s + k) % 8] : exp_stage[(s + k) % 8]);
      end
      breset();
    end
  endtask

  task automatic expect_silent(input string tag);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(tag, {7'd0, tx_valid}, 8'h00);
    end
  endtask

  initial begin
    logic [7:0] b;
    for (int i = 0; i < 8; i++) begin
      exp_stage[i] = 8'h00;
      exp_otp[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 rx_ready", {7'd0, rx_ready}, 8'h01);
    check("R12 tx_valid", {7'd0, tx_valid}, 8'h00);
    read_all("R12 zero contents", 1'b0);
    read_status("R4 open status repeated", 8'hFF, 3);

    send(8'h66); send(8'h01);
    expect_silent("R5 wrong status key");
    breset();

    for (int s = 0; s < 8; s++) begin
      send(8'h99);
      send(8'(s) | 8'hF8);
      for (int k = 0; k < 10; k++) begin
        send(8'(s * 16 + k + 1));
        exp_stage[(s + k) % 8] = 8'(s * 16 + k + 1);
      end
      breset();
      read_all("R1 R3 stage write and wrap", 1'b0);
    end

    send(8'hC3); send(8'h02);
    @(negedge clk);
    b = tx_data;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2 tx held valid", {7'd0, tx_valid}, 8'h01);
      check("R2 rx_ready low while offering", {7'd0, rx_ready}, 8'h00);
      check("R2 tx_data held", tx_data, b);
    end
    check("R2 stalled byte", b, exp_stage[2]);
    breset();
    check("R10 stream idle after reset", {7'd0, tx_valid}, 8'h00);

    send(8'h0F); send(8'hC3); send(8'h00);
    expect_silent("R11 unknown command");
    breset();

    send(8'h5A);
    breset();
    read_status("R7 cancel by reset", 8'hFF, 1);
    send(8'h5A); send(8'h5A);
    breset();
    read_status("R7 wrong seal key", 8'hFF, 1);

    send(8'h5A);
    @(negedge clk);
    rx_data = 8'hA5; rx_valid = 1'b1; bus_reset = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; bus_reset = 1'b0;
    check("R10 ready after reset", {7'd0, rx_ready}, 8'h01);
    read_status("R10 key with reset ignored", 8'hFF, 1);
    read_all("R10 contents kept", 1'b0);

    send(8'h5A); send(8'hA5);
    breset();
    for (int i = 0; i < 8; i++) exp_otp[i] = exp_stage[i];
    read_status("R6 sealed status", 8'hFC, 2);
    read_all("R6 reads from otp", 1'b1);

    send(8'h99); send(8'h00);
    for (int k = 0; k < 8; k++) send(8'(8'h3C + k));
    breset();
    read_all("R8 writes discarded", 1'b1);

    send(8'h5A); send(8'hA5);
    breset();
    read_status("R9 second seal status", 8'hFC, 1);
    read_all("R9 second seal contents", 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule